// File: doc/BRIEF.md
# CPU Interrupt Interface with Priority Preemption

This block sits between the interrupt distributor's per-CPU output and one processor core. The distributor presents the highest-priority pending interrupt: a valid flag, its ID and its 8-bit priority. The block compares that priority against a software-programmed mask and against the priority of the interrupt the core is already servicing. When both tests pass, it raises the core's interrupt request line. Lower numbers mean more urgent. Only the upper four priority bits are implemented. The lower four are dropped on every input and read back as zero.

Software talks to the block through a small word-addressed register port. A read of the claim register acknowledges the pending interrupt. The read returns its ID, pushes its priority onto an internal active stack, and pulses an acknowledge strobe to the distributor. A write to the done register retires the most recent active interrupt. It pops the stack, restores the previous running priority and pulses a deactivate strobe carrying the written ID. The split register holds the binary point. The binary point chooses which upper bits of a priority form the group field that governs preemption. The remaining lower bits are sub-priority, and they never let one interrupt preempt another.

Register map (3-bit word address): 0 mask (read/write), 1 split (read/write), 2 claim (read), 3 done (write), 4 running priority (read), 5 peek pending ID (read), 6 spurious count (read). Reads of the done register and of unused addresses return zero.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the mask reads 0x00, the split reads 3, the running priority reads 0xFF, the spurious count reads 0, and `irq_o` is low.
- R2: Only priority bits [7:4] are kept. A mask write stores only wdata[7:4], and the mask reads back with bits [3:0] zero. Bits [3:0] of `pend_prio_i` have no effect on any decision.
- R3: A split write stores wdata[2:0], except that a value below 3 is stored as 3. The split reads back as a 3-bit value.
- R4: An interrupt can only be signalled when its priority bits [7:4] are strictly less than the mask bits [7:4]. Equal or higher is blocked.
- R5: With an interrupt already active, a new one is signalled only when its group field is strictly less than that of the running priority. With split value b, the group field is priority bits [7:b+1]. With nothing active, the group test always passes.
- R6: `irq_o` is combinational. A claim read while `irq_o` is high returns the pending ID in rdata[9:0] and pulses `ack_o` in the same cycle, with `ack_id_o` equal to that ID. It pushes the priority (low four bits zero) so that the running priority reads it from the next cycle.
- R7: A claim read while `irq_o` is low returns 1023, raises no `ack_o`, leaves the running priority unchanged, and increments the spurious count by one.
- R8: A done write while the stack is non-empty pulses `deact_o` in that cycle, with `deact_id_o` = wdata[9:0]. It pops the stack, and the running priority becomes the new top entry, or 0xFF when the stack is empty.
- R9: A done write while the stack is empty raises no `deact_o` and leaves the running priority at 0xFF.
- R10: The active stack holds one entry per implemented priority level (16). A chain of strictly increasing urgency down to priority 0x00 never overflows it, and unwinds in reverse order.
- R11: The peek register returns `pend_id_i` when `pend_valid_i` is high and 1023 otherwise, with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_valid_i | input | 1 | Distributor has a pending interrupt for this CPU |
| pend_id_i | input | 10 | ID of the highest pending interrupt |
| pend_prio_i | input | 8 | Priority of the highest pending interrupt |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| ack_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | 10 | ID being acknowledged |
| deact_o | output | 1 | Deactivate strobe to the distributor |
| deact_id_o | output | 10 | ID being deactivated |

## Verification
The bench uses the default parameters: 10-bit IDs, 8-bit priorities with 4 implemented bits, a 16-entry active stack and a 16-bit spurious counter. With only sixteen priority levels, random claim/done traffic regularly builds deep nesting chains. Sweeping the split value 0 to 7 covers the clamp to 3, a group field of every width from four bits down to none, and the case where nothing can preempt a running handler. A directed chain claims priorities 0xE0 down to 0x00 to push the stack to its deepest reachable level and unwind it.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;
  typedef enum logic [2:0] {
    REG_MASK    = 3'd0,
    REG_SPLIT   = 3'd1,
    REG_CLAIM   = 3'd2,
    REG_DONE    = 3'd3,
    REG_RUNNING = 3'd4,
    REG_PEEK    = 3'd5,
    REG_SPUR    = 3'd6
  } reg_sel_e;

  localparam int unsigned SPUR_ID_VAL = 1023;
endpackage

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_val_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     ent_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o) cnt_q <= cnt_q - 1'b1;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[k] <= '0;
      else if (push_i && cnt_q == CNT_W'(k)) ent_q[k] <= push_val_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (cnt_q == CNT_W'(k + 1)) top_o = ent_q[k];
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/irq_preempt_check.sv
module irq_preempt_check #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned IMPL_W = 4,
  parameter int unsigned BP_W   = 3,
  localparam int unsigned DROP_W = PRIO_W - IMPL_W
) (
  input  logic              pend_valid_i,
  input  logic [IMPL_W-1:0] pend_i,
  input  logic [IMPL_W-1:0] mask_i,
  input  logic [BP_W-1:0]   split_i,
  input  logic [IMPL_W-1:0] run_i,
  input  logic              idle_i,
  output logic              qualify_o
);
  logic [IMPL_W-1:0] gmask;

  // implemented bit j sits at full-width position j+DROP_W; group keeps positions > split
  for (genvar j = 0; j < IMPL_W; j++) begin : g_gmask
    assign gmask[j] = (32'(split_i) + 32'd1) <= 32'(j + DROP_W);
  end

  logic below_mask, group_win;
  assign below_mask = pend_i < mask_i;
  assign group_win  = idle_i || ((pend_i & gmask) < (run_i & gmask));
  assign qualify_o  = pend_valid_i && below_mask && group_win;
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cif_pkg::*;
#(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned IMPL_W = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned SPUR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_valid_i,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              deact_o,
  output logic [ID_W-1:0]   deact_id_o
);
  localparam int unsigned DROP_W = PRIO_W - IMPL_W;
  localparam int unsigned BP_W   = $clog2(PRIO_W);
  localparam logic [BP_W-1:0] BP_MIN  = BP_W'(DROP_W - 1);
  localparam logic [ID_W-1:0] SPUR_ID = ID_W'(SPUR_ID_VAL);

  logic [IMPL_W-1:0] mask_q;
  logic [BP_W-1:0]   split_q;
  logic [SPUR_W-1:0] spur_q;
  logic [IMPL_W-1:0] pend_hi, top_prio;
  logic              stack_empty, stack_full, qualify;
  logic              claim_rd, done_wr, push, pop;
  logic [PRIO_W-1:0] run_prio;
  logic [BP_W-1:0]   split_wr;

  assign pend_hi  = pend_prio_i[PRIO_W-1 -: IMPL_W];
  assign run_prio = stack_empty ? '1 : {top_prio, {DROP_W{1'b0}}};

  irq_preempt_check #(.PRIO_W(PRIO_W), .IMPL_W(IMPL_W), .BP_W(BP_W)) u_check (
    .pend_valid_i (pend_valid_i),
    .pend_i       (pend_hi),
    .mask_i       (mask_q),
    .split_i      (split_q),
    .run_i        (top_prio),
    .idle_i       (stack_empty),
    .qualify_o    (qualify)
  );

  assign claim_rd = reg_rd_i && (reg_addr_i == REG_CLAIM);
  assign done_wr  = reg_wr_i && (reg_addr_i == REG_DONE);
  assign push     = claim_rd && qualify;
  assign pop      = done_wr && !stack_empty;

  irq_prio_stack #(.W(IMPL_W), .DEPTH(DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_val_i (pend_hi),
    .top_o      (top_prio),
    .empty_o    (stack_empty),
    .full_o     (stack_full)
  );

  assign split_wr = reg_wdata_i[BP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      split_q <= BP_MIN;
      spur_q  <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == REG_MASK)  mask_q  <= reg_wdata_i[PRIO_W-1 -: IMPL_W];
      if (reg_wr_i && reg_addr_i == REG_SPLIT) split_q <= (split_wr < BP_MIN) ? BP_MIN : split_wr;
      if (claim_rd && !qualify)                spur_q  <= spur_q + 1'b1;
    end
  end

  assign irq_o      = qualify;
  assign ack_o      = push;
  assign ack_id_o   = pend_id_i;
  assign deact_o    = pop;
  assign deact_id_o = reg_wdata_i[ID_W-1:0];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (reg_addr_i)
        REG_MASK:    reg_rdata_o = 32'({mask_q, {DROP_W{1'b0}}});
        REG_SPLIT:   reg_rdata_o = 32'(split_q);
        REG_CLAIM:   reg_rdata_o = 32'(qualify ? pend_id_i : SPUR_ID);
        REG_RUNNING: reg_rdata_o = 32'(run_prio);
        REG_PEEK:    reg_rdata_o = 32'(pend_valid_i ? pend_id_i : SPUR_ID);
        REG_SPUR:    reg_rdata_o = 32'(spur_q);
        default:     reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_cif_chk.sv
module irq_cif_chk #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned IMPL_W = 4,
  parameter int unsigned SPUR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              ack_o,
  input logic              deact_o,
  input logic [PRIO_W-1:0] pend_prio_i,
  input logic [IMPL_W-1:0] mask_q,
  input logic [PRIO_W-1:0] run_prio,
  input logic              push,
  input logic              stack_full,
  input logic              stack_empty,
  input logic              claim_rd,
  input logic [SPUR_W-1:0] spur_q
);
  p_ack_needs_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> irq_o);

  p_mask_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_prio_i[PRIO_W-1 -: IMPL_W] < mask_q));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> !stack_full);

  p_claim_deepens_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (run_prio < $past(run_prio)));

  p_spur_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_rd && !irq_o) |=> (spur_q == $past(spur_q) + 1'b1));

  p_deact_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_o |-> !stack_empty);
endmodule

bind irq_cpu_if irq_cif_chk #(.PRIO_W(PRIO_W), .IMPL_W(IMPL_W), .SPUR_W(SPUR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .ack_o       (ack_o),
  .deact_o     (deact_o),
  .pend_prio_i (pend_prio_i),
  .mask_q      (mask_q),
  .run_prio    (run_prio),
  .push        (push),
  .stack_full  (stack_full),
  .stack_empty (stack_empty),
  .claim_rd    (claim_rd),
  .spur_q      (spur_q)
);

// File: tb/sim_irq_cpu_if.sv
`timescale 1ns/1ps
module sim_irq_cpu_if;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pend_valid_i = 1'b0;
  logic [9:0]  pend_id_i = '0;
  logic [7:0]  pend_prio_i = '0;
  logic        reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, ack_o, deact_o;
  logic [9:0]  ack_id_o, deact_id_o;

  always #2.5 clk_i = ~clk_i;

  irq_cpu_if u0 (.*);

  int n_chk = 0, n_fail = 0;
  int m_mask = 0, m_split = 3, m_sp = 0, m_spur = 0;
  int m_stk [16];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int m_run();
    return (m_sp == 0) ? 'hFF : m_stk[m_sp-1];
  endfunction

  function automatic bit m_qual();
    int e, gm;
    e  = int'(pend_prio_i) & 'hF0;
    gm = ('hFF << (m_split + 1)) & 'hFF;
    return pend_valid_i && (e < m_mask) && (m_sp == 0 || ((e & gm) < (m_run() & gm)));
  endfunction

  // drive after negedge, check before the posedge, then update the model
  task automatic op(bit rd, bit wr, int addr, int wdata, string req);
    bit q;
    int exp;
    @(negedge clk_i);
    reg_rd_i = rd; reg_wr_i = wr; reg_addr_i = 3'(addr); reg_wdata_i = wdata;
    #1;
    q = m_qual();
    chk({req, " irq"}, int'(irq_o), int'(q));
    chk({req, " ack"}, int'(ack_o), int'(rd && addr == 2 && q));
    chk({req, " deact"}, int'(deact_o), int'(wr && addr == 3 && m_sp > 0));
    if (ack_o) chk({req, " ack_id"}, int'(ack_id_o), int'(pend_id_i));
    if (deact_o) chk({req, " deact_id"}, int'(deact_id_o), wdata & 'h3FF);
    if (rd) begin
      case (addr)
        0: exp = m_mask;
        1: exp = m_split;
        2: exp = q ? int'(pend_id_i) : 1023;
        4: exp = m_run();
        5: exp = pend_valid_i ? int'(pend_id_i) : 1023;
        6: exp = m_spur & 'hFFFF;
        default: exp = 0;
      endcase
      chk({req, " rdata"}, int'(reg_rdata_o), exp);
    end
    if (wr && addr == 0) m_mask = wdata & 'hF0;
    if (wr && addr == 1) m_split = ((wdata & 7) < 3) ? 3 : (wdata & 7);
    if (rd && addr == 2) begin
      if (q) begin m_stk[m_sp] = int'(pend_prio_i) & 'hF0; m_sp++; end
      else m_spur++;
    end
    if (wr && addr == 3 && m_sp > 0) m_sp--;
    @(posedge clk_i);
    #0.5;
    reg_rd_i = 0; reg_wr_i = 0;
  endtask

  task automatic pend(bit v, int id, int pr);
    @(negedge clk_i);
    pend_valid_i = v; pend_id_i = 10'(id); pend_prio_i = 8'(pr);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    // R1 reset values
    op(1, 0, 0, 0, "R1 mask");
    op(1, 0, 1, 0, "R1 split");
    op(1, 0, 4, 0, "R1 running");
    op(1, 0, 6, 0, "R1 spur");
    pend(1, 9, 'h00);
    op(1, 0, 5, 0, "R1 irq blocked by zero mask / R11 peek");
    // R2 low bits dropped
    op(0, 1, 0, 'hAB, "R2 mask wr");
    op(1, 0, 0, 0, "R2 mask rd");
    // R3 clamp
    op(0, 1, 1, 1, "R3 wr1");
    op(1, 0, 1, 0, "R3 rd clamp");
    op(0, 1, 1, 5, "R3 wr5");
    op(1, 0, 1, 0, "R3 rd5");
    op(0, 1, 1, 3, "R3 wr3");
    // R4 strict mask, R2 low pend bits ignored
    op(0, 1, 0, 'h80, "R4 mask80");
    pend(1, 17, 'h80);
    op(1, 0, 5, 0, "R4 equal blocked");
    pend(1, 17, 'h7F);
    op(1, 0, 5, 0, "R2 7F passes as 70");
    // R7 spurious claim
    pend(0, 17, 'h10);
    op(1, 0, 2, 0, "R7 claim none");
    op(1, 0, 6, 0, "R7 spur rd");
    op(1, 0, 4, 0, "R7 running same");
    // R5/R6/R8 nesting
    op(0, 1, 0, 'hF0, "R6 maskF0");
    pend(1, 5, 'h80);
    op(1, 0, 2, 0, "R6 claim 80");
    op(1, 0, 4, 0, "R6 running 80");
    pend(1, 6, 'h8C);
    op(1, 0, 2, 0, "R5 same group spurious");
    pend(1, 6, 'h70);
    op(1, 0, 2, 0, "R6 claim 70");
    op(0, 1, 1, 5, "R5 split5");
    pend(1, 7, 'h40);
    op(1, 0, 5, 0, "R5 same group 40 vs 70");
    pend(1, 7, 'h30);
    op(1, 0, 2, 0, "R5 claim 30 group wins");
    op(0, 1, 1, 7, "R5 split7");
    pend(1, 8, 'h00);
    op(1, 0, 5, 0, "R5 no group field");
    op(0, 1, 3, 7, "R8 done 7");
    op(0, 1, 3, 6, "R8 done 6");
    op(1, 0, 4, 0, "R8 running 80");
    op(0, 1, 3, 5, "R8 done 5");
    op(1, 0, 4, 0, "R8 running FF");
    op(0, 1, 3, 5, "R9 done empty");
    op(1, 0, 4, 0, "R9 running FF");
    // R10 deepest chain
    op(0, 1, 1, 3, "R10 split3");
    for (int p = 14; p >= 0; p--) begin
      pend(1, 100 + p, p * 16);
      op(1, 0, 2, 0, "R10 claim chain");
    end
    op(1, 0, 4, 0, "R10 running 00");
    for (int p = 0; p < 15; p++) op(0, 1, 3, 100 + p, "R10 unwind");
    op(1, 0, 4, 0, "R10 running FF");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      pend($urandom % 4 != 0, $urandom % 1024, $urandom % 256);
      r = $urandom % 16;
      if (r == 0)       op(0, 1, 0, $urandom % 256, "R2 rnd mask");
      else if (r == 1)  op(0, 1, 1, $urandom % 8, "R3 rnd split");
      else if (r < 7)   op(1, 0, 2, 0, "R6 rnd claim");
      else if (r < 11)  op(0, 1, 3, $urandom % 1024, "R8 rnd done");
      else if (r == 11) op(1, 0, 4, 0, "R8 rnd running");
      else if (r == 12) op(1, 0, 5, 0, "R11 rnd peek");
      else if (r == 13) op(1, 0, 6, 0, "R7 rnd spur");
      else if (r == 14) op(1, 0, 0, 0, "R4 rnd mask rd");
      else              op(0, 0, 0, 0, "R5 rnd idle");
    end
    finish_run();
  end
endmodule